// File: doc/BRIEF.md
# Downstream Request Arbiter

This block sits between a cache's miss queue, its write buffer and a hardware prefetcher, and picks the one request that goes downstream next. It looks at the head entry of each queue, the pending and allocated entries of both queues, and one candidate prefetch address. Each cycle it returns a one-hot grant and the index of the queue entry to send. The decision is combinational. A registered counter records how many prefetches were granted.

Two address checks keep the order of requests to the same block. A write that was picked gives way to an older pending miss to the same block. A miss that was picked gives way to any pending write to the same block. A prefetch is tried only when neither queue has a ready head and the miss queue can take a prefetch. The prefetch is dropped when its block is already cached or already held in either queue. The arbiter also reports the earliest time at which any source becomes ready.

Top module: `req_arbiter`

## Requirements
- R1: `gnt_o` has at most one bit set. Bit 0 grants a miss, bit 1 grants a write and bit 2 grants a prefetch. All zero means no grant.
- R2: The write source is chosen when `wr_rdy_i` is high and either `miss_rdy_i` is low, or `wb_full_i` is high with `wb_svc_i` equal to 0.
- R3: When the write source is not chosen and `miss_rdy_i` is high, the miss source is chosen.
- R4: When the write source is chosen, the arbiter finds the lowest-index miss-queue entry that is pending, has the same block address and has the same secure bit as the write head. If that entry's order stamp is strictly smaller than `wr_ord_i`, the grant is a miss with `gnt_idx_o` set to that entry. Otherwise the grant is a write with `gnt_idx_o` = `wr_idx_i`.
- R5: When the miss source is chosen, the arbiter looks for a pending write-buffer entry with the same block address and secure bit as the miss head. If one exists, the grant is a write with `gnt_idx_o` set to the lowest such index, and order stamps are not compared. Otherwise the grant is a miss with `gnt_idx_o` = `miss_idx_i`.
- R6: A prefetch is considered only when both ready flags are low and `mq_can_pf_i` and `pf_vld_i` are both high. `pf_lkup_addr_o` always equals `pf_addr_i` with its low log2(block bytes) bits cleared, and the tag-array result `tag_hit_i` refers to that address.
- R7: A prefetch that is considered is dropped (no grant) when one of these holds: `tag_hit_i` is high, a valid miss-queue entry has the same block address and secure bit, or a valid write-buffer entry has the same block address and secure bit. Otherwise it is granted. `pf_ack_o` is high whenever a prefetch is considered, whether it is granted or dropped.
- R8: `next_rdy_o` is the smaller of `mq_time_i` and `wb_time_i`. When `mq_can_pf_i` is high, `pf_time_i` also takes part in the minimum.
- R9: `pf_cnt_o` is 0 after reset. It increases by one, wrapping, on every clock edge at which a prefetch is granted, and holds otherwise.
- R10: `gnt_idx_o` is 0 when the grant is a prefetch or there is no grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_rdy_i | input | 1 | Miss-queue head is ready |
| miss_addr_i | input | AW | Miss head block address |
| miss_sec_i | input | 1 | Miss head secure bit |
| miss_idx_i | input | IDXW | Miss head entry index |
| wr_rdy_i | input | 1 | Write-buffer head is ready |
| wr_addr_i | input | AW | Write head block address |
| wr_sec_i | input | 1 | Write head secure bit |
| wr_ord_i | input | OW | Write head order stamp |
| wr_idx_i | input | IDXW | Write head entry index |
| wb_full_i | input | 1 | Write buffer is full |
| wb_svc_i | input | SVCW | Write entries in service |
| mq_vld_i | input | NMQ | Miss entries allocated |
| mq_pend_i | input | NMQ | Miss entries pending (not in service) |
| mq_addr_i | input | NMQ x AW | Miss entry block addresses |
| mq_sec_i | input | NMQ | Miss entry secure bits |
| mq_ord_i | input | NMQ x OW | Miss entry order stamps |
| wb_vld_i | input | NWB | Write entries allocated |
| wb_pend_i | input | NWB | Write entries pending |
| wb_addr_i | input | NWB x AW | Write entry block addresses |
| wb_sec_i | input | NWB | Write entry secure bits |
| mq_can_pf_i | input | 1 | Miss queue can accept a prefetch |
| pf_vld_i | input | 1 | Prefetcher offers a candidate |
| pf_addr_i | input | AW | Candidate byte address |
| pf_sec_i | input | 1 | Candidate secure bit |
| tag_hit_i | input | 1 | Tag array holds the aligned candidate |
| mq_time_i | input | TW | Miss queue ready time |
| wb_time_i | input | TW | Write buffer ready time |
| pf_time_i | input | TW | Prefetcher ready time |
| gnt_o | output | 3 | One-hot grant {prefetch, write, miss} |
| gnt_idx_o | output | IDXW | Entry index to send |
| pf_ack_o | output | 1 | Candidate consumed |
| pf_lkup_addr_o | output | AW | Block-aligned candidate address |
| next_rdy_o | output | TW | Earliest ready time |
| pf_cnt_o | output | CNTW | Granted prefetch count |

## Verification
The sweep covers every combination of the ready, full, in-service, can-prefetch, candidate and tag-hit flags, against many address and secure-bit layouts. This catches a design that ignores the in-service count and lets a full buffer starve misses. The equal-stamp write-over-miss case is hit, so it catches an order test of less-or-equal that sends an equally old miss in place of the write. Layouts that differ only in the secure bit catch a match that drops the secure compare, which would wrongly reroute grants or drop prefetches. Unaligned candidate addresses catch a prefetch check done on the raw address. Randomised ready times catch a design that counts the prefetcher's time even when the miss queue refuses prefetches.

// File: rtl/req_arb_pkg.sv
package req_arb_pkg;
  localparam int unsigned GNT_W = 3;
  localparam int unsigned GNT_MISS = 0;
  localparam int unsigned GNT_WR = 1;
  localparam int unsigned GNT_PF = 2;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_MISS,
    SRC_WR,
    SRC_PF
  } src_e;
endpackage

// File: rtl/req_arb_match.sv
module req_arb_match #(
  parameter int unsigned N    = 4,
  parameter int unsigned AW   = 16,
  parameter int unsigned OFFW = 4,
  parameter int unsigned IW   = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]         en_i,
  input  logic [N-1:0][AW-1:0] addr_i,
  input  logic [N-1:0]         sec_i,
  input  logic [AW-1:0]        key_addr_i,
  input  logic                 key_sec_i,
  output logic                 hit_o,
  output logic [IW-1:0]        idx_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = en_i[g] && (sec_i[g] == key_sec_i) &&
                      (addr_i[g][AW-1:OFFW] == key_addr_i[AW-1:OFFW]);
  end

  // lowest matching index wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/req_arb_rdy_time.sv
module req_arb_rdy_time #(
  parameter int unsigned TW = 16
) (
  input  logic [TW-1:0] mq_time_i,
  input  logic [TW-1:0] wb_time_i,
  input  logic [TW-1:0] pf_time_i,
  input  logic          pf_ok_i,
  output logic [TW-1:0] next_o
);
  logic [TW-1:0] q_min;

  always_comb begin
    q_min = (mq_time_i < wb_time_i) ? mq_time_i : wb_time_i;
    next_o = q_min;
    if (pf_ok_i && (pf_time_i < q_min)) next_o = pf_time_i;
  end
endmodule

// File: rtl/req_arb_pf_cnt.sv
module req_arb_pf_cnt #(
  parameter int unsigned CNTW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inc_i,
  output logic [CNTW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (inc_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/req_arbiter.sv
module req_arbiter
  import req_arb_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned BLK_BYTES = 16,
  parameter int unsigned NMQ       = 4,
  parameter int unsigned NWB       = 4,
  parameter int unsigned OW        = 8,
  parameter int unsigned TW        = 16,
  parameter int unsigned CNTW      = 8,
  localparam int unsigned OFFW     = $clog2(BLK_BYTES),
  localparam int unsigned MQW      = $clog2(NMQ),
  localparam int unsigned WBW      = $clog2(NWB),
  localparam int unsigned IDXW     = (MQW > WBW) ? MQW : WBW,
  localparam int unsigned SVCW     = $clog2(NWB + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   miss_rdy_i,
  input  logic [AW-1:0]          miss_addr_i,
  input  logic                   miss_sec_i,
  input  logic [IDXW-1:0]        miss_idx_i,
  input  logic                   wr_rdy_i,
  input  logic [AW-1:0]          wr_addr_i,
  input  logic                   wr_sec_i,
  input  logic [OW-1:0]          wr_ord_i,
  input  logic [IDXW-1:0]        wr_idx_i,
  input  logic                   wb_full_i,
  input  logic [SVCW-1:0]        wb_svc_i,
  input  logic [NMQ-1:0]         mq_vld_i,
  input  logic [NMQ-1:0]         mq_pend_i,
  input  logic [NMQ-1:0][AW-1:0] mq_addr_i,
  input  logic [NMQ-1:0]         mq_sec_i,
  input  logic [NMQ-1:0][OW-1:0] mq_ord_i,
  input  logic [NWB-1:0]         wb_vld_i,
  input  logic [NWB-1:0]         wb_pend_i,
  input  logic [NWB-1:0][AW-1:0] wb_addr_i,
  input  logic [NWB-1:0]         wb_sec_i,
  input  logic                   mq_can_pf_i,
  input  logic                   pf_vld_i,
  input  logic [AW-1:0]          pf_addr_i,
  input  logic                   pf_sec_i,
  input  logic                   tag_hit_i,
  input  logic [TW-1:0]          mq_time_i,
  input  logic [TW-1:0]          wb_time_i,
  input  logic [TW-1:0]          pf_time_i,
  output logic [GNT_W-1:0]       gnt_o,
  output logic [IDXW-1:0]        gnt_idx_o,
  output logic                   pf_ack_o,
  output logic [AW-1:0]          pf_lkup_addr_o,
  output logic [TW-1:0]          next_rdy_o,
  output logic [CNTW-1:0]        pf_cnt_o
);
  localparam logic [AW-1:0] OFF_MASK = AW'(BLK_BYTES - 1);

  logic           wr_conf_hit, miss_conf_hit, pf_mq_hit, pf_wb_hit;
  logic [MQW-1:0] wr_conf_idx, pf_mq_idx;
  logic [WBW-1:0] miss_conf_idx, pf_wb_idx;
  logic           wr_first, pf_try, pf_block;
  src_e           src;

  assign pf_lkup_addr_o = pf_addr_i & ~OFF_MASK;

  // pending miss blocking the write head
  req_arb_match #(.N(NMQ), .AW(AW), .OFFW(OFFW), .IW(MQW)) i_wr_conf (
    .en_i(mq_pend_i), .addr_i(mq_addr_i), .sec_i(mq_sec_i),
    .key_addr_i(wr_addr_i), .key_sec_i(wr_sec_i),
    .hit_o(wr_conf_hit), .idx_o(wr_conf_idx)
  );

  // pending write blocking the miss head
  req_arb_match #(.N(NWB), .AW(AW), .OFFW(OFFW), .IW(WBW)) i_miss_conf (
    .en_i(wb_pend_i), .addr_i(wb_addr_i), .sec_i(wb_sec_i),
    .key_addr_i(miss_addr_i), .key_sec_i(miss_sec_i),
    .hit_o(miss_conf_hit), .idx_o(miss_conf_idx)
  );

  // prefetch already held in either queue
  req_arb_match #(.N(NMQ), .AW(AW), .OFFW(OFFW), .IW(MQW)) i_pf_mq (
    .en_i(mq_vld_i), .addr_i(mq_addr_i), .sec_i(mq_sec_i),
    .key_addr_i(pf_lkup_addr_o), .key_sec_i(pf_sec_i),
    .hit_o(pf_mq_hit), .idx_o(pf_mq_idx)
  );

  req_arb_match #(.N(NWB), .AW(AW), .OFFW(OFFW), .IW(WBW)) i_pf_wb (
    .en_i(wb_vld_i), .addr_i(wb_addr_i), .sec_i(wb_sec_i),
    .key_addr_i(pf_lkup_addr_o), .key_sec_i(pf_sec_i),
    .hit_o(pf_wb_hit), .idx_o(pf_wb_idx)
  );

  assign wr_first = wr_rdy_i && (!miss_rdy_i || (wb_full_i && (wb_svc_i == '0)));
  assign pf_try   = !miss_rdy_i && !wr_rdy_i && mq_can_pf_i && pf_vld_i;
  assign pf_block = tag_hit_i || pf_mq_hit || pf_wb_hit;
  assign pf_ack_o = pf_try;

  always_comb begin
    src       = SRC_NONE;
    gnt_idx_o = '0;
    if (wr_first) begin
      if (wr_conf_hit && (mq_ord_i[wr_conf_idx] < wr_ord_i)) begin
        src       = SRC_MISS;
        gnt_idx_o = IDXW'(wr_conf_idx);
      end else begin
        src       = SRC_WR;
        gnt_idx_o = wr_idx_i;
      end
    end else if (miss_rdy_i) begin
      if (miss_conf_hit) begin
        src       = SRC_WR;
        gnt_idx_o = IDXW'(miss_conf_idx);
      end else begin
        src       = SRC_MISS;
        gnt_idx_o = miss_idx_i;
      end
    end else if (pf_try && !pf_block) begin
      src = SRC_PF;
    end
  end

  always_comb begin
    gnt_o = '0;
    unique case (src)
      SRC_MISS: gnt_o[GNT_MISS] = 1'b1;
      SRC_WR:   gnt_o[GNT_WR]   = 1'b1;
      SRC_PF:   gnt_o[GNT_PF]   = 1'b1;
      default:  gnt_o = '0;
    endcase
  end

  req_arb_rdy_time #(.TW(TW)) i_rdy_time (
    .mq_time_i(mq_time_i), .wb_time_i(wb_time_i), .pf_time_i(pf_time_i),
    .pf_ok_i(mq_can_pf_i), .next_o(next_rdy_o)
  );

  req_arb_pf_cnt #(.CNTW(CNTW)) i_pf_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(gnt_o[GNT_PF]), .cnt_o(pf_cnt_o)
  );
endmodule

// File: rtl/req_arbiter_chk.sv
module req_arbiter_chk #(
  parameter int unsigned AW   = 16,
  parameter int unsigned TW   = 16,
  parameter int unsigned CNTW = 8,
  parameter int unsigned IDXW = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            miss_rdy_i,
  input logic            wr_rdy_i,
  input logic            mq_can_pf_i,
  input logic            pf_vld_i,
  input logic            tag_hit_i,
  input logic [TW-1:0]   mq_time_i,
  input logic [TW-1:0]   wb_time_i,
  input logic [2:0]      gnt_o,
  input logic [IDXW-1:0] gnt_idx_o,
  input logic            pf_ack_o,
  input logic [TW-1:0]   next_rdy_o,
  input logic [CNTW-1:0] pf_cnt_o
);
  p_gnt_onehot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  p_wr_served_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_rdy_i && !miss_rdy_i) |-> (gnt_o[1] || gnt_o[0]));

  p_miss_served_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_rdy_i && !wr_rdy_i) |-> (gnt_o[1] || gnt_o[0]));

  p_pf_idle_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o[2] |-> (!miss_rdy_i && !wr_rdy_i && mq_can_pf_i && pf_vld_i));

  p_pf_tag_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_ack_o && tag_hit_i) |-> !gnt_o[2]);

  p_pf_acked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o[2] |-> pf_ack_o);

  p_rdy_min_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (next_rdy_o <= mq_time_i) && (next_rdy_o <= wb_time_i));

  p_cnt_inc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_o[2] |=> (pf_cnt_o == CNTW'($past(pf_cnt_o) + 1'b1)));

  p_cnt_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gnt_o[2] |=> $stable(pf_cnt_o));

  p_idx_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o[2] || (gnt_o == 3'b000)) |-> (gnt_idx_o == '0));
endmodule

bind req_arbiter req_arbiter_chk #(
  .AW(AW), .TW(TW), .CNTW(CNTW), .IDXW(IDXW)
) i_req_arbiter_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .miss_rdy_i(miss_rdy_i), .wr_rdy_i(wr_rdy_i),
  .mq_can_pf_i(mq_can_pf_i), .pf_vld_i(pf_vld_i), .tag_hit_i(tag_hit_i),
  .mq_time_i(mq_time_i), .wb_time_i(wb_time_i), .gnt_o(gnt_o),
  .gnt_idx_o(gnt_idx_o), .pf_ack_o(pf_ack_o), .next_rdy_o(next_rdy_o),
  .pf_cnt_o(pf_cnt_o)
);

// File: tb/test_req_arbiter.sv
module test_req_arbiter;
  localparam int AW = 16, BLK = 16, NMQ = 4, NWB = 4, OW = 8, TW = 16, CNTW = 8;
  localparam int OFFW = 4, IDXW = 2, SVCW = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic                   miss_rdy, miss_sec, wr_rdy, wr_sec, wb_full;
  logic [AW-1:0]          miss_addr, wr_addr, pf_addr;
  logic [IDXW-1:0]        miss_idx, wr_idx;
  logic [OW-1:0]          wr_ord;
  logic [SVCW-1:0]        wb_svc;
  logic [NMQ-1:0]         mq_vld, mq_pend, mq_sec;
  logic [NMQ-1:0][AW-1:0] mq_addr;
  logic [NMQ-1:0][OW-1:0] mq_ord;
  logic [NWB-1:0]         wb_vld, wb_pend, wb_sec;
  logic [NWB-1:0][AW-1:0] wb_addr;
  logic                   can_pf, pf_vld, pf_sec, tag_hit;
  logic [TW-1:0]          mq_t, wb_t, pf_t;
  logic [2:0]             gnt;
  logic [IDXW-1:0]        gnt_idx;
  logic                   pf_ack;
  logic [AW-1:0]          lkup;
  logic [TW-1:0]          nxt;
  logic [CNTW-1:0]        cnt;

  req_arbiter i_req_arbiter (
    .clk_i(clk), .rst_ni(rst_ni),
    .miss_rdy_i(miss_rdy), .miss_addr_i(miss_addr), .miss_sec_i(miss_sec), .miss_idx_i(miss_idx),
    .wr_rdy_i(wr_rdy), .wr_addr_i(wr_addr), .wr_sec_i(wr_sec), .wr_ord_i(wr_ord), .wr_idx_i(wr_idx),
    .wb_full_i(wb_full), .wb_svc_i(wb_svc),
    .mq_vld_i(mq_vld), .mq_pend_i(mq_pend), .mq_addr_i(mq_addr), .mq_sec_i(mq_sec), .mq_ord_i(mq_ord),
    .wb_vld_i(wb_vld), .wb_pend_i(wb_pend), .wb_addr_i(wb_addr), .wb_sec_i(wb_sec),
    .mq_can_pf_i(can_pf), .pf_vld_i(pf_vld), .pf_addr_i(pf_addr), .pf_sec_i(pf_sec),
    .tag_hit_i(tag_hit), .mq_time_i(mq_t), .wb_time_i(wb_t), .pf_time_i(pf_t),
    .gnt_o(gnt), .gnt_idx_o(gnt_idx), .pf_ack_o(pf_ack), .pf_lkup_addr_o(lkup),
    .next_rdy_o(nxt), .pf_cnt_o(cnt)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] rng = 32'h1234_5678;
  logic [CNTW-1:0] exp_cnt = '0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] s);
    logic [31:0] v = s;
    v ^= v << 13; v ^= v >> 17; v ^= v << 5;
    return v;
  endfunction

  function automatic logic [AW-1:0] blk_addr(input logic [31:0] r);
    return AW'(((r % 3) + 1) << OFFW);
  endfunction

  initial begin
    #(20ns * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    {miss_rdy, miss_sec, wr_rdy, wr_sec, wb_full, can_pf, pf_vld, pf_sec, tag_hit} = '0;
    {miss_addr, wr_addr, pf_addr, miss_idx, wr_idx, wr_ord, wb_svc} = '0;
    {mq_vld, mq_pend, mq_sec, mq_addr, mq_ord, wb_vld, wb_pend, wb_sec, wb_addr} = '0;
    {mq_t, wb_t, pf_t} = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset count", 32'(cnt), 0);
    rst_ni = 1'b1;

    for (int k = 0; k < 4096; k++) begin
      logic [6:0] c = k[6:0];
      logic wr_first, wc_hit, mc_hit, pm_hit, pw_hit, try_pf;
      int wc_i, mc_i;
      logic [2:0] e_gnt;
      logic [IDXW-1:0] e_idx;
      logic [TW-1:0] e_nxt;
      string tag;
      @(negedge clk);
      miss_rdy = c[0]; wr_rdy = c[1]; wb_full = c[2]; can_pf = c[4]; pf_vld = c[5]; tag_hit = c[6];
      rng = step(rng); wb_svc = c[3] ? '0 : SVCW'(1 + rng % NWB);
      rng = step(rng); miss_addr = blk_addr(rng); miss_sec = rng[8]; miss_idx = rng[10:9];
      rng = step(rng); wr_addr = blk_addr(rng); wr_sec = rng[8]; wr_idx = rng[10:9]; wr_ord = OW'(rng[15:12]);
      rng = step(rng); pf_addr = blk_addr(rng) | AW'(rng[11:8]); pf_sec = rng[16];
      for (int i = 0; i < NMQ; i++) begin
        rng = step(rng);
        mq_addr[i] = blk_addr(rng); mq_sec[i] = rng[8] & rng[20];
        mq_vld[i] = rng[9] & rng[21]; mq_pend[i] = mq_vld[i] & rng[10];
        mq_ord[i] = OW'(rng[15:12]);
      end
      for (int i = 0; i < NWB; i++) begin
        rng = step(rng);
        wb_addr[i] = blk_addr(rng); wb_sec[i] = rng[8] & rng[20];
        wb_vld[i] = rng[9] & rng[21]; wb_pend[i] = wb_vld[i] & rng[10];
      end
      rng = step(rng); mq_t = rng[15:0]; wb_t = rng[31:16];
      rng = step(rng); pf_t = rng[15:0];

      // reference decision
      wc_hit = 0; wc_i = 0; mc_hit = 0; mc_i = 0; pm_hit = 0; pw_hit = 0;
      for (int i = NMQ - 1; i >= 0; i--) begin
        if (mq_pend[i] && mq_sec[i] == wr_sec && mq_addr[i] == wr_addr) begin wc_hit = 1; wc_i = i; end
        if (mq_vld[i] && mq_sec[i] == pf_sec && mq_addr[i] == (pf_addr & ~AW'(BLK - 1))) pm_hit = 1;
      end
      for (int i = NWB - 1; i >= 0; i--) begin
        if (wb_pend[i] && wb_sec[i] == miss_sec && wb_addr[i] == miss_addr) begin mc_hit = 1; mc_i = i; end
        if (wb_vld[i] && wb_sec[i] == pf_sec && wb_addr[i] == (pf_addr & ~AW'(BLK - 1))) pw_hit = 1;
      end
      wr_first = wr_rdy && (!miss_rdy || (wb_full && wb_svc == 0));
      try_pf = !miss_rdy && !wr_rdy && can_pf && pf_vld;
      e_gnt = 3'b000; e_idx = '0; tag = "R10 idle";
      if (wr_first) begin
        if (wc_hit && mq_ord[wc_i] < wr_ord) begin e_gnt = 3'b001; e_idx = IDXW'(wc_i); tag = "R4 older miss"; end
        else begin e_gnt = 3'b010; e_idx = wr_idx; tag = "R2 write first"; end
      end else if (miss_rdy) begin
        if (mc_hit) begin e_gnt = 3'b010; e_idx = IDXW'(mc_i); tag = "R5 write conflict"; end
        else begin e_gnt = 3'b001; e_idx = miss_idx; tag = "R3 miss"; end
      end else if (try_pf) begin
        if (tag_hit || pm_hit || pw_hit) tag = "R7 pf dropped";
        else begin e_gnt = 3'b100; tag = "R6 pf granted"; end
      end
      e_nxt = (mq_t < wb_t) ? mq_t : wb_t;
      if (can_pf && pf_t < e_nxt) e_nxt = pf_t;

      #2;
      chk(tag, 32'(gnt), 32'(e_gnt));
      chk({tag, " R1 idx"}, 32'(gnt_idx), 32'(e_idx));
      chk("R7 ack", 32'(pf_ack), 32'(try_pf));
      chk("R6 align", 32'(lkup), 32'(pf_addr & ~AW'(BLK - 1)));
      chk("R8 next ready", 32'(nxt), 32'(e_nxt));
      if (e_gnt[2]) exp_cnt = exp_cnt + 1'b1;
      @(posedge clk); #2;
      chk("R9 count", 32'(cnt), 32'(exp_cnt));
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule